// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the row strobes of an asynchronous DRAM for everything except ordinary reads and writes. After reset it keeps both strobes high for a programmable settling delay, then runs a fixed number of CAS-before-RAS (CBR) cycles to initialise the part. Only then does it declare the memory ready. From that point a free-running interval timer adds refresh credits to a small saturating counter. A request flag tells the access controller that credit is pending. Each grant turns one credit into a CBR cycle on the strobes.

The access controller can also put the memory into self refresh with a one-cycle enter command. The block drops CAS, then RAS, and holds both low for a minimum hold time before it will act on an exit command. Exit raises both strobes and enforces a precharge gap. Pending credits are discarded on entry, and the interval timer restarts from zero once the exit precharge ends. Because CBR refresh uses the memory's own row counter, the block has no address or data path. All delays are counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n_o` and `cas_n_o` are 1, `ref_req_o` and `init_done_o` are 0, and `busy_o` is 1.
- R2: After reset is released, both strobes stay high for at least `PWRUP_CYC` cycles before CAS first falls.
- R3: Exactly `INIT_CYCLES` CBR cycles are driven before `init_done_o` rises. `ref_req_o` stays 0 until then, and `gnt_i` has no effect during that phase. Once high, `init_done_o` stays high until reset.
- R4: Every refresh cycle has the same shape. CAS falls with RAS high, and RAS falls `CSR_CYC` cycles later. CAS rises `CHR_CYC` cycles after RAS falls, and RAS rises `RAS_LOW_CYC` cycles after it falls. Both strobes then stay high for at least `RP_CYC` cycles before CAS falls again. RAS never falls while CAS is high.
- R5: After `init_done_o` rises, one refresh credit is added every `REF_INTERVAL` cycles. `ref_req_o` is 1 exactly while at least one credit is pending, and it first rises `REF_INTERVAL` cycles after `init_done_o`.
- R6: Pending credits saturate at `PEND_MAX`. With grant held, exactly that many back-to-back CBR cycles drain the count to zero.
- R7: A grant seen while `ref_req_o` is 1 and no cycle is running lowers CAS one cycle later and takes one credit. A grant with no pending credit causes no strobe activity.
- R8: `busy_o` is 1 before initialisation is done, and it is 1 whenever a strobe is low or a precharge gap is running. Otherwise it is 0.
- R9: A `sr_enter_i` pulse while idle and ready starts self refresh. CAS falls first, and RAS falls `CSR_CYC` cycles later. Both strobes then stay low for at least `SR_HOLD_CYC` cycles, and `sr_exit_i` has no effect during that hold.
- R10: After the hold, `sr_exit_i` raises both strobes on the next cycle. `busy_o` stays 1 for `SR_PRE_CYC` cycles and then falls. `ref_req_o` then rises `REF_INTERVAL` cycles after `busy_o` falls.
- R11: When `sr_enter_i` and a valid grant arrive in the same cycle, self refresh wins and all pending credits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Access controller grants the strobes for one refresh |
| sr_enter_i | input | 1 | Command to enter self refresh |
| sr_exit_i | input | 1 | Command to leave self refresh |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low |
| ref_req_o | output | 1 | At least one refresh credit is pending |
| busy_o | output | 1 | The sequencer owns the strobes |
| init_done_o | output | 1 | Power-up wait and initialisation cycles are complete |

## Verification
The request path is exercised with four grant patterns, each pinning down a different part of the credit logic:
- Grant held high through initialisation shows that grant cannot add cycles before the part is ready.
- Withholding grant for several intervals and then draining separates a saturating counter from a wrapping or single-bit one.
- A grant held while no credit is pending shows that grant alone never starts a cycle.
- A grant waiting when a credit arrives measures the one-cycle start latency.

Self refresh is entered with two credits pending and a grant in the same cycle. This separates entry priority and credit clearing from an ordinary refresh. An exit pulse during the hold, and a later valid one, separate a hold counter from an immediate exit. Every strobe cycle is measured against a queue of expected cycle shapes.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_ACTIVE,
    ENG_PRE,
    ENG_SR_SETUP,
    ENG_SR_ENTRY,
    ENG_SR_STAY,
    ENG_SR_PRE
  } eng_state_e;

  typedef enum logic [1:0] {
    SEQ_PWRUP,
    SEQ_INIT,
    SEQ_RUN
  } seq_state_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Length in cycles of each timed engine state
  function automatic int unsigned eng_limit(input eng_state_e s,
                                            input int unsigned csr, input int unsigned rlo,
                                            input int unsigned rp, input int unsigned srh,
                                            input int unsigned srp);
    case (s)
      ENG_SETUP, ENG_SR_SETUP: return csr;
      ENG_ACTIVE:              return rlo;
      ENG_PRE:                 return rp;
      ENG_SR_ENTRY:            return srh;
      ENG_SR_PRE:              return srp;
      default:                 return 1;
    endcase
  endfunction

  // Credit count update: a take is applied first, then a saturating add
  function automatic int unsigned pend_next(input int unsigned cur, input logic add,
                                            input logic take, input int unsigned lim);
    int unsigned v;
    v = cur;
    if (take && v > 0) v = v - 1;
    if (add && v < lim) v = v + 1;
    return v;
  endfunction

endpackage

// File: rtl/dram_ref_tick.sv
module dram_ref_tick #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_ref_pend.sv
module dram_ref_pend
  import dram_ref_pkg::*;
#(
  parameter int unsigned PEND_MAX = 4,
  localparam int unsigned PW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_i,
  input  logic          take_i,
  input  logic          clr_i,
  output logic [PW-1:0] cnt_o,
  output logic          nz_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= PW'(pend_next(32'(cnt_q), add_i, take_i, PEND_MAX));
  end

  assign cnt_o = cnt_q;
  assign nz_o  = (cnt_q != '0);
endmodule

// File: rtl/dram_cbr_engine.sv
module dram_cbr_engine
  import dram_ref_pkg::*;
#(
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 2,
  parameter int unsigned RAS_LOW_CYC = 9,
  parameter int unsigned RP_CYC      = 5,
  parameter int unsigned SR_HOLD_CYC = 10000,
  parameter int unsigned SR_PRE_CYC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ref_i,
  input  logic start_sr_i,
  input  logic sr_exit_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic idle_o,
  output logic sr_mode_o
);
  localparam int unsigned MAXC = max_of4(max_of4(CSR_CYC, RAS_LOW_CYC, RP_CYC, 1),
                                         SR_HOLD_CYC, SR_PRE_CYC, 1);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  if (CHR_CYC >= RAS_LOW_CYC || CSR_CYC == 0 || RP_CYC == 0 || SR_PRE_CYC == 0) begin : g_bad_timing
    $error("CBR engine timing parameters out of range");
  end

  eng_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == CW'(eng_limit(st_q, CSR_CYC, RAS_LOW_CYC, RP_CYC,
                                        SR_HOLD_CYC, SR_PRE_CYC) - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? '0 : cnt_q + 1'b1;
    unique case (st_q)
      ENG_IDLE: begin
        cnt_d = '0;
        if (start_sr_i)       st_d = ENG_SR_SETUP;
        else if (start_ref_i) st_d = ENG_SETUP;
      end
      ENG_SETUP:    if (last) st_d = ENG_ACTIVE;
      ENG_ACTIVE:   if (last) st_d = ENG_PRE;
      ENG_PRE:      if (last) st_d = ENG_IDLE;
      ENG_SR_SETUP: if (last) st_d = ENG_SR_ENTRY;
      ENG_SR_ENTRY: if (last) st_d = ENG_SR_STAY;
      ENG_SR_STAY: begin
        cnt_d = '0;
        if (sr_exit_i) st_d = ENG_SR_PRE;
      end
      ENG_SR_PRE:   if (last) st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  logic ras_low, cas_low;
  assign ras_low = (st_q == ENG_ACTIVE) || (st_q == ENG_SR_ENTRY) || (st_q == ENG_SR_STAY);
  assign cas_low = (st_q == ENG_SETUP) || (st_q == ENG_SR_SETUP) ||
                   (st_q == ENG_SR_ENTRY) || (st_q == ENG_SR_STAY) ||
                   ((st_q == ENG_ACTIVE) && (cnt_q < CW'(CHR_CYC)));

  assign ras_n_o   = !ras_low;
  assign cas_n_o   = !cas_low;
  assign idle_o    = (st_q == ENG_IDLE);
  assign sr_mode_o = (st_q == ENG_SR_SETUP) || (st_q == ENG_SR_ENTRY) ||
                     (st_q == ENG_SR_STAY) || (st_q == ENG_SR_PRE);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned PWRUP_CYC    = 20000,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned PEND_MAX     = 4,
  parameter int unsigned CSR_CYC      = 1,
  parameter int unsigned CHR_CYC      = 2,
  parameter int unsigned RAS_LOW_CYC  = 9,
  parameter int unsigned RP_CYC       = 5,
  parameter int unsigned SR_HOLD_CYC  = 10000,
  parameter int unsigned SR_PRE_CYC   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt_i,
  input  logic sr_enter_i,
  input  logic sr_exit_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic ref_req_o,
  output logic busy_o,
  output logic init_done_o
);
  localparam int unsigned PWC = $clog2(PWRUP_CYC + 1);
  localparam int unsigned IW  = $clog2(INIT_CYCLES + 1);
  localparam int unsigned PW  = $clog2(PEND_MAX + 1);

  seq_state_e     seq_q;
  logic [PWC-1:0] pw_cnt_q;
  logic [IW-1:0]  init_cnt_q;

  // Named internal events
  logic          run, eng_idle, sr_mode, tick, pend_nz;
  logic          start_init, start_ref, start_sr;
  logic [PW-1:0] pend_cnt;

  assign run        = (seq_q == SEQ_RUN);
  assign start_init = (seq_q == SEQ_INIT) && eng_idle && (init_cnt_q != IW'(INIT_CYCLES));
  assign start_sr   = run && eng_idle && sr_enter_i;
  assign start_ref  = run && eng_idle && pend_nz && gnt_i && !sr_enter_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SEQ_PWRUP;
      pw_cnt_q   <= '0;
      init_cnt_q <= '0;
    end else begin
      unique case (seq_q)
        SEQ_PWRUP: begin
          if (pw_cnt_q == PWC'(PWRUP_CYC - 1)) seq_q <= SEQ_INIT;
          else                                 pw_cnt_q <= pw_cnt_q + 1'b1;
        end
        SEQ_INIT: begin
          if (start_init) init_cnt_q <= init_cnt_q + 1'b1;
          else if (eng_idle && init_cnt_q == IW'(INIT_CYCLES)) seq_q <= SEQ_RUN;
        end
        SEQ_RUN: seq_q <= SEQ_RUN;
        default: seq_q <= SEQ_PWRUP;
      endcase
    end
  end

  dram_ref_tick #(.INTERVAL(REF_INTERVAL)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (run && !sr_mode),
    .tick_o(tick)
  );

  dram_ref_pend #(.PEND_MAX(PEND_MAX)) pend_i (
    .clk   (clk),
    .rst_n (rst_n),
    .add_i (tick),
    .take_i(start_ref),
    .clr_i (start_sr),
    .cnt_o (pend_cnt),
    .nz_o  (pend_nz)
  );

  dram_cbr_engine #(
    .CSR_CYC    (CSR_CYC),
    .CHR_CYC    (CHR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .RP_CYC     (RP_CYC),
    .SR_HOLD_CYC(SR_HOLD_CYC),
    .SR_PRE_CYC (SR_PRE_CYC)
  ) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ref_i(start_ref || start_init),
    .start_sr_i (start_sr),
    .sr_exit_i  (sr_exit_i),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .idle_o     (eng_idle),
    .sr_mode_o  (sr_mode)
  );

  assign init_done_o = run;
  assign ref_req_o   = run && pend_nz;
  assign busy_o      = !run || !eng_idle;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned PEND_MAX    = 4,
  parameter int unsigned PW          = 3,
  parameter int unsigned RAS_LOW_CYC = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gnt_i,
  input logic          ras_n_o,
  input logic          cas_n_o,
  input logic          ref_req_o,
  input logic          busy_o,
  input logic          init_done_o,
  input logic [PW-1:0] pend_cnt,
  input logic          start_ref,
  input logic          sr_mode
);
  logic [15:0] low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_len <= '0;
    else if (ras_n_o)       low_len <= '0;
    else if (low_len != '1) low_len <= low_len + 1'b1;
  end

  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> !cas_n_o);

  // R4
  cas_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o && $past(!ras_n_o)) |-> !$fell(cas_n_o));

  // R4
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n_o) && !sr_mode) |-> (low_len >= 16'(RAS_LOW_CYC)));

  // R3
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_o |-> !ref_req_o);

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);

  // R6
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(PEND_MAX));

  // R7
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ref |-> (ref_req_o && gnt_i));

  // R8
  busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o || !cas_n_o) |-> busy_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PEND_MAX   (PEND_MAX),
  .PW         (PW),
  .RAS_LOW_CYC(RAS_LOW_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .gnt_i      (gnt_i),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .ref_req_o  (ref_req_o),
  .busy_o     (busy_o),
  .init_done_o(init_done_o),
  .pend_cnt   (pend_cnt),
  .start_ref  (start_ref),
  .sr_mode    (sr_mode)
);

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
  localparam int PWRUP = 50;
  localparam int NINIT = 8;
  localparam int INTV  = 100;
  localparam int PMAX  = 3;
  localparam int CSR   = 2;
  localparam int CHR   = 3;
  localparam int RLO   = 5;
  localparam int RP    = 4;
  localparam int SRH   = 30;
  localparam int SRP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic ras_n, cas_n, req, busy, idone;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CYCLES(NINIT), .REF_INTERVAL(INTV), .PEND_MAX(PMAX),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_LOW_CYC(RLO), .RP_CYC(RP),
    .SR_HOLD_CYC(SRH), .SR_PRE_CYC(SRP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .gnt_i(gnt), .sr_enter_i(sr_enter), .sr_exit_i(sr_exit),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .ref_req_o(req), .busy_o(busy), .init_done_o(idone)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Scoreboard of expected strobe cycles
  typedef struct { bit is_sr; string rq; } exp_t;
  exp_t exp_q[$];

  task automatic push_cbr(input int n, input string rq);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.is_sr = 1'b0; e.rq = rq;
      exp_q.push_back(e);
    end
  endtask

  task automatic push_sr(input string rq);
    exp_t e;
    e.is_sr = 1'b1; e.rq = rq;
    exp_q.push_back(e);
  endtask

  int ncnt = 0;
  always @(posedge clk) ncnt <= ncnt + 1;

  // Monitor: measures each strobe cycle and compares with the queue head
  logic pr_ras = 1'b1, pr_cas = 1'b1;
  int setup_c = 0, low_c = 0, hold_c = 0, high_c = 0;
  int cas_falls = 0, cyc_done = 0;
  bit first_fall = 1'b1, req_early = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      setup_c = 0; low_c = 0; hold_c = 0; high_c = 0;
      pr_ras = 1'b1; pr_cas = 1'b1; first_fall = 1'b1;
    end else begin
      if (!idone && req) req_early = 1'b1;
      if (pr_cas && !cas_n && ras_n) begin
        cas_falls++;
        if (first_fall)
          chk(high_c >= PWRUP && high_c <= PWRUP + 3, "R2", "high cycles before first CAS fall",
              high_c, PWRUP);
        else
          chk(high_c >= RP, "R4", "precharge gap before CAS fall", high_c, RP);
        first_fall = 1'b0;
        setup_c = 0;
      end
      if (!pr_ras && ras_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected strobe cycle", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(setup_c == CSR, e.rq, "CAS-to-RAS setup", setup_c, CSR);
          if (!e.is_sr) begin
            chk(low_c == RLO, e.rq, "RAS low width", low_c, RLO);
            chk(hold_c == CHR, e.rq, "CAS hold after RAS fall", hold_c, CHR);
          end else begin
            chk(low_c >= SRH, e.rq, "self refresh low time", low_c, SRH);
            chk(hold_c == low_c, e.rq, "CAS low for whole self refresh", hold_c, low_c);
          end
        end
        cyc_done++;
        setup_c = 0; low_c = 0; hold_c = 0; high_c = 0;
      end
      if (ras_n && cas_n) high_c++;
      if (ras_n && !cas_n) setup_c++;
      if (!ras_n) begin
        low_c++;
        if (!cas_n) hold_c++;
      end
      pr_ras = ras_n;
      pr_cas = cas_n;
    end
  end

  task automatic wait_until(input int t);
    while (ncnt < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin : main
    int t0, ts, cf, guard;
    gnt = 1'b1;                 // held through init: must not matter (R3)
    push_cbr(NINIT, "R3");
    repeat (3) @(negedge clk);
    chk(ras_n == 1'b1, "R1", "ras_n in reset", ras_n, 1);
    chk(cas_n == 1'b1, "R1", "cas_n in reset", cas_n, 1);
    chk(req == 1'b0, "R1", "ref_req in reset", req, 0);
    chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
    chk(idone == 1'b0, "R1", "init_done in reset", idone, 0);
    rst_n = 1'b1;

    guard = 0;
    while (!idone && guard < 5000) begin @(negedge clk); guard++; end
    t0 = ncnt;
    gnt = 1'b0;
    chk(cyc_done == NINIT, "R3", "init cycles before init_done", cyc_done, NINIT);
    chk(exp_q.size() == 0, "R3", "init cycles outstanding", exp_q.size(), 0);
    chk(busy == 1'b0, "R8", "busy after init when idle", busy, 0);

    wait_until(t0 + INTV - 1);
    chk(req == 1'b0, "R5", "req one cycle before first interval", req, 0);
    wait_until(t0 + INTV);
    chk(req == 1'b1, "R5", "req at first interval", req, 1);
    chk(busy == 1'b0, "R8", "busy with only a pending credit", busy, 0);

    // Saturation: four intervals elapsed, at most PMAX credits held
    wait_until(t0 + 4 * INTV + 1);
    chk(req == 1'b1, "R6", "req while credits saturated", req, 1);
    cf = cas_falls;
    push_cbr(PMAX, "R6");
    gnt = 1'b1;
    guard = 0;
    while (req && guard < 200) begin @(negedge clk); guard++; end
    while (busy && guard < 200) begin @(negedge clk); guard++; end
    chk(cas_falls - cf == PMAX, "R6", "cycles to drain saturated credits", cas_falls - cf, PMAX);

    // Grant held without credit: no strobe activity
    cf = cas_falls;
    wait_until(t0 + 5 * INTV - 1);
    chk(cas_falls == cf, "R7", "strobe cycles with grant but no credit", cas_falls - cf, 0);
    chk(cas_n == 1'b1, "R7", "cas_n idle with grant but no credit", cas_n, 1);
    push_cbr(1, "R7");
    wait_until(t0 + 5 * INTV);
    chk(req == 1'b1, "R5", "req at fifth interval", req, 1);
    wait_until(t0 + 5 * INTV + 1);
    chk(cas_n == 1'b0, "R7", "CAS low one cycle after grant", cas_n, 0);
    chk(req == 1'b0, "R7", "credit taken by grant", req, 0);
    gnt = 1'b0;
    wait_until(t0 + 5 * INTV + 20);
    chk(busy == 1'b0, "R8", "busy after refresh cycle", busy, 0);

    // Self refresh entered with two credits pending and a grant present
    ts = t0 + 7 * INTV;
    wait_until(ts);
    chk(req == 1'b1, "R11", "req before self refresh", req, 1);
    push_sr("R9");
    sr_enter = 1'b1;
    gnt = 1'b1;
    wait_until(ts + 1);
    sr_enter = 1'b0;
    gnt = 1'b0;
    chk(req == 1'b0, "R11", "credits cleared by self refresh entry", req, 0);
    chk(cas_n == 1'b0 && ras_n == 1'b1, "R9", "CAS first on entry", {cas_n, ras_n}, 1);
    wait_until(ts + 10);
    sr_exit = 1'b1;             // too early: must be ignored
    wait_until(ts + 11);
    sr_exit = 1'b0;
    wait_until(ts + 15);
    chk(ras_n == 1'b0, "R9", "RAS low after early exit", ras_n, 0);
    wait_until(ts + 40);
    chk(ras_n == 1'b0 && cas_n == 1'b0, "R9", "strobes low in self refresh",
        {ras_n, cas_n}, 0);
    sr_exit = 1'b1;
    wait_until(ts + 41);
    sr_exit = 1'b0;
    chk(ras_n == 1'b1 && cas_n == 1'b1, "R10", "strobes high after exit", {ras_n, cas_n}, 3);
    wait_until(ts + 40 + SRP);
    chk(busy == 1'b1, "R10", "busy during exit precharge", busy, 1);
    wait_until(ts + 41 + SRP);
    chk(busy == 1'b0, "R10", "busy after exit precharge", busy, 0);
    wait_until(ts + 40 + SRP + INTV);
    chk(req == 1'b0, "R10", "req before restarted interval", req, 0);
    wait_until(ts + 41 + SRP + INTV);
    chk(req == 1'b1, "R10", "req at restarted interval", req, 1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "expected cycles not seen", exp_q.size(), 0);
    chk(req_early == 1'b0, "R3", "req before init_done", req_early, 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule